// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block decides when a remote wake-up request has arrived on a LIN bus while the transceiver rests in one of its low-power modes. It sees two digitized views of the bus. One is the pre-wake comparator, which is high while the bus sits below the pre-wake threshold. The other is the receiver output, which is high for recessive. A microsecond tick clocks a saturating counter that measures how long both views agree on dominant.

A wake-up is declared only at the moment the bus goes back to recessive, and only if the dominant phase that just ended lasted at least the filter time. The result is a single-cycle pulse to the mode controller. After one pulse the filter stays disarmed until the mode controller leaves low power and enters it again.

All inputs are taken to be synchronous to `clk_i`. The choice of threshold voltages and of operating mode belongs to other blocks.

Top module: `lin_wake_filter`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `wake_o` is 0.
- R2: `wake_o` rises only after the bus returns to recessive (`prewake_i`=0 and `bus_i`=1) at the end of a dominant phase that counted at least `FILT_TICKS` ticks (default 100). It never rises while the phase is still dominant.
- R3: A dominant phase that counted fewer than `FILT_TICKS` ticks gives no pulse, and its count is discarded. Two short phases whose sum exceeds the threshold do not wake the block.
- R4: `wake_o` is high for exactly one cycle. That cycle is the one after the clock edge that samples the recessive return.
- R5: After a pulse, further qualifying phases are ignored until both `sleep_i` and `silent_i` have been low and one of them is raised again. Arming takes effect from the cycle after entry.
- R6: With `sleep_i`=0 and `silent_i`=0, no dominant phase produces a pulse.
- R7: In silent mode (`silent_i`=1, `sleep_i`=0), wake-up is accepted only while `txd_i`=1. A phase seen while `txd_i`=0 gives no pulse. In sleep mode `txd_i` has no effect.
- R8: A bus already dominant when low power is entered (for example a short to ground) is timed from the cycle after entry, and it wakes the block once the bus is released.
- R9: The counter saturates. A dominant phase of 300 ticks, longer than the counter's wrap length, still wakes the block.
- R10: Only cycles with `tick_us_i`=1 advance the count. With one tick every 4 cycles, 396 dominant cycles give no pulse and 400 give a pulse.
- R11: A split bus view (`prewake_i`=1 with `bus_i`=1, or `prewake_i`=0 with `bus_i`=0) neither advances the count nor ends the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| sleep_i | input | 1 | Sleep mode is active |
| silent_i | input | 1 | Silent mode is active |
| txd_i | input | 1 | TXD pin level (1 = high) |
| prewake_i | input | 1 | Bus below the pre-wake threshold (1 = dominant) |
| bus_i | input | 1 | Receiver output (1 = recessive) |
| wake_o | output | 1 | Single-cycle remote wake-up pulse |

## Verification
Each result has a fixed due cycle. A mode entry arms the filter at the clock edge that samples it, so counting starts one edge later. Every edge that samples a dominant bus with a tick adds one to the count. The wake pulse appears after the edge that samples the recessive return and is gone one edge after that. The bench drives every input on the falling clock edge and counts dominant phases in sampled rising edges. It checks `wake_o` on the next falling edge, which keeps each check exactly one register stage behind its stimulus. `wake_o` is also checked low on every cycle of each dominant phase.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  typedef enum logic [1:0] {
    BUS_REC   = 2'd0,
    BUS_DOM   = 2'd1,
    BUS_SPLIT = 2'd2
  } bus_lvl_e;

  // prewake high = below threshold, bus high = recessive
  function automatic bus_lvl_e bus_classify(input logic prewake, input logic bus);
    if (prewake && !bus)      return BUS_DOM;
    else if (!prewake && bus) return BUS_REC;
    else                      return BUS_SPLIT;
  endfunction

endpackage

// File: rtl/lin_wake_arm.sv
module lin_wake_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic silent_i,
  input  logic txd_i,
  input  logic fire_i,
  output logic lp_o,
  output logic armed_o,
  output logic active_o
);

  logic lp_q;
  logic en;

  assign lp_o = sleep_i | silent_i;
  // silent needs TXD high, sleep ignores TXD
  assign en   = sleep_i | (silent_i & txd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q    <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      lp_q <= lp_o;
      if (!lp_o)             armed_o <= 1'b0;
      else if (!lp_q)        armed_o <= 1'b1;
      else if (fire_i)       armed_o <= 1'b0;
    end
  end

  assign active_o = armed_o & en;

endmodule

// File: rtl/lin_wake_timer.sv
module lin_wake_timer #(
  parameter int unsigned FILT_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic qualified_o
);

  localparam int unsigned CNT_W = $clog2(FILT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign qualified_o = (cnt_q == CNT_MAX);

  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int unsigned FILT_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic sleep_i,
  input  logic silent_i,
  input  logic txd_i,
  input  logic prewake_i,
  input  logic bus_i,
  output logic wake_o
);
  import lin_wake_pkg::*;

  bus_lvl_e lvl;
  logic     dom, rel;
  logic     lp, armed, active;
  logic     qualified;
  logic     fire;

  assign lvl = bus_classify(prewake_i, bus_i);
  assign dom = (lvl == BUS_DOM);
  assign rel = (lvl == BUS_REC);

  lin_wake_arm u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .silent_i (silent_i),
    .txd_i    (txd_i),
    .fire_i   (fire),
    .lp_o     (lp),
    .armed_o  (armed),
    .active_o (active)
  );

  lin_wake_timer #(.FILT_TICKS(FILT_TICKS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (!active || rel),
    .step_i      (active && dom && tick_us_i),
    .qualified_o (qualified)
  );

  // declare only on the recessive return after a qualified phase
  assign fire = active & rel & qualified;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= 1'b0;
    else         wake_o <= fire;
  end

  // R4
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R2
  qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(qualified));

  // R5
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !armed);

  // R6
  awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp |=> !wake_o);

  // R7
  silent_txd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (silent_i && !sleep_i && !txd_i) |=> !wake_o);

endmodule

// File: tb/lin_wake_filter_tb.sv
module lin_wake_filter_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_us_i = 1'b1;
  logic sleep_i = 1'b0;
  logic silent_i = 1'b0;
  logic txd_i = 1'b1;
  logic prewake_i = 1'b0;
  logic bus_i = 1'b1;
  logic wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lin_wake_filter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_us_i (tick_us_i),
    .sleep_i   (sleep_i),
    .silent_i  (silent_i),
    .txd_i     (txd_i),
    .prewake_i (prewake_i),
    .bus_i     (bus_i),
    .wake_o    (wake_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input logic sl, input logic si, input logic tx);
    @(negedge clk);
    sleep_i = sl; silent_i = si; txd_i = tx;
    repeat (2) @(negedge clk);
  endtask

  // drive n cycles of a bus view; ticks on every div-th cycle; wake_o must stay low
  task automatic bus_cycles(input int n, input int div, input logic pre, input logic bus,
                            input string req);
    for (int i = 0; i < n; i++) begin
      prewake_i = pre; bus_i = bus;
      tick_us_i = (div <= 1) ? 1'b1 : ((i % div) == div - 1);
      @(negedge clk);
      if (wake_o !== 1'b0) chk(req, wake_o, 1'b0);
    end
    tick_us_i = 1'b1;
  endtask

  task automatic release_chk(input logic exp, input string req);
    prewake_i = 1'b0; bus_i = 1'b1; tick_us_i = 1'b1;
    @(negedge clk);
    chk(req, wake_o, exp);
    @(negedge clk);
    chk("R4", wake_o, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", wake_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", wake_o, 1'b0);
  endtask

  task automatic t_basic;
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(100, 1, 1'b1, 1'b0, "R2");
    release_chk(1'b1, "R2");
  endtask

  task automatic t_rearm;
    bus_cycles(120, 1, 1'b1, 1'b0, "R5");
    release_chk(1'b0, "R5");
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(100, 1, 1'b1, 1'b0, "R5");
    release_chk(1'b1, "R5");
  endtask

  task automatic t_short;
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(99, 1, 1'b1, 1'b0, "R3");
    release_chk(1'b0, "R3");
    bus_cycles(60, 1, 1'b1, 1'b0, "R3");
    release_chk(1'b0, "R3");
    bus_cycles(60, 1, 1'b1, 1'b0, "R3");
    release_chk(1'b0, "R3");
  endtask

  task automatic t_awake;
    set_mode(1'b0, 1'b0, 1'b1);
    bus_cycles(150, 1, 1'b1, 1'b0, "R6");
    release_chk(1'b0, "R6");
  endtask

  task automatic t_silent;
    set_mode(1'b0, 1'b1, 1'b0);
    bus_cycles(150, 1, 1'b1, 1'b0, "R7");
    release_chk(1'b0, "R7");
    set_mode(1'b0, 1'b1, 1'b1);
    bus_cycles(100, 1, 1'b1, 1'b0, "R7");
    release_chk(1'b1, "R7");
    set_mode(1'b0, 1'b0, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0);
    bus_cycles(100, 1, 1'b1, 1'b0, "R7");
    release_chk(1'b1, "R7");
  endtask

  task automatic t_short_entry;
    set_mode(1'b0, 1'b0, 1'b1);
    bus_cycles(30, 1, 1'b1, 1'b0, "R8");
    sleep_i = 1'b1;
    bus_cycles(110, 1, 1'b1, 1'b0, "R8");
    release_chk(1'b1, "R8");
  endtask

  task automatic t_saturate;
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(300, 1, 1'b1, 1'b0, "R9");
    release_chk(1'b1, "R9");
  endtask

  task automatic t_tick;
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(396, 4, 1'b1, 1'b0, "R10");
    release_chk(1'b0, "R10");
    bus_cycles(400, 4, 1'b1, 1'b0, "R10");
    release_chk(1'b1, "R10");
  endtask

  task automatic t_split;
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(60, 1, 1'b1, 1'b0, "R11");
    bus_cycles(50, 1, 1'b1, 1'b1, "R11");
    bus_cycles(40, 1, 1'b1, 1'b0, "R11");
    release_chk(1'b1, "R11");
    set_mode(1'b0, 1'b0, 1'b1);
    set_mode(1'b1, 1'b0, 1'b1);
    bus_cycles(60, 1, 1'b1, 1'b0, "R11");
    bus_cycles(50, 1, 1'b0, 1'b0, "R11");
    bus_cycles(39, 1, 1'b1, 1'b0, "R11");
    release_chk(1'b0, "R11");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_rearm;
    t_short;
    t_awake;
    t_silent;
    t_short_entry;
    t_saturate;
    t_tick;
    t_split;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule